// File: doc/BRIEF.md
# Motor Stall Lock Timer

This block detects a stalled brushless motor from its rotation-speed pulse line and gates the low-side drive while the stall lasts. It mimics a timing capacitor with a saturating up/down accumulator. While the motor is not locked, the accumulator climbs by a programmable charge step on every prescaled tick. Every transition of the synchronized speed pulse input snaps it back to zero, so a turning motor keeps it near zero. If no transition arrives before the accumulator reaches the high threshold, the lock flag rises. The accumulator then descends by a smaller discharge step per tick. Once it drops under the low threshold, the flag clears and charging resumes from that level. This lock and release cycle repeats until the motor turns again.

The charge and discharge steps differ, and the two thresholds are far apart. As a result the first lock takes longer than every later re-lock, and each release lasts about ten re-lock times with the default steps of 10 and 1. A strap input disables protection entirely and holds the accumulator at zero. The thresholds and steps are plain inputs and may change at run time.

Top module: `stall_guard`

## Requirements
- R1: During reset and on its release, lockFlag is 0 and the accumulator is 0.
- R2: The fgIn level passes through a two-stage synchronizer. Each transition of the synchronized level, rising or falling, clears the accumulator to 0. A motor whose fgIn toggles more often than once per lock time therefore never locks.
- R3: While unlocked, the accumulator gains chargeStep once every TICK_DIV clock cycles (default 4) and holds between ticks. lockFlag rises the cycle after the accumulator is greater than or equal to highThresh.
- R4: While locked, the accumulator loses dischargeStep once per tick. lockFlag falls the cycle after the accumulator is strictly less than lowThresh.
- R5: On release the accumulator is not cleared. Re-lock time is therefore about (highThresh - lowThresh) / chargeStep ticks, which is shorter than the first lock time of highThresh / chargeStep ticks.
- R6: Without fgIn transitions, lock and release alternate indefinitely.
- R7: A transition on fgIn while locked clears lockFlag and restarts charging from 0.
- R8: While lockDisable is 1, the accumulator is held at 0 and lockFlag is 0 from the next cycle on.
- R9: highThresh, lowThresh, chargeStep and dischargeStep are sampled every cycle and take effect without reset.
- R10: The accumulator saturates at 2^ACC_W-1 going up and at 0 going down; it never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| fgIn | input | 1 | Rotation pulse level, asynchronous |
| lockDisable | input | 1 | 1 = protection cancelled |
| chargeStep | input | ACC_W | Accumulator increment per tick while unlocked |
| dischargeStep | input | ACC_W | Accumulator decrement per tick while locked |
| highThresh | input | ACC_W | Lock threshold |
| lowThresh | input | ACC_W | Release threshold |
| lockFlag | output | 1 | 1 = stall detected, low-side drive must be off |

## Verification
The main cycle is run with the default settings and no pulses. This measures the first lock, the slow release, the short re-lock and the repeat, so the charge rate, the discharge rate and the absence of a clear on release can each be told apart. A pulse train spaced inside the lock time separates clear-on-edge from a missing clear. A single pulse during lock shows that the accumulator restarts from zero and not from the low threshold. A second setting with other thresholds and steps confirms run-time programming. Large steps against a full-scale threshold expose wrap-around at either end.

// File: rtl/stall_pkg.sv
package stall_pkg;

  // Commands from the control to the accumulator datapath
  typedef struct packed {
    logic clear;
    logic up;
    logic down;
  } accCmd_t;

  // Compare results from the datapath back to the control
  typedef struct packed {
    logic geHigh;
    logic ltLow;
  } accFlags_t;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_LOCKED = 1'b1
  } lockState_t;

endpackage

// File: rtl/stall_fg_edge.sv
module stall_fg_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic fgIn,
  output logic fgEdge
);

  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[SYNC_STAGES-1:0], fgIn};
  end

  assign fgEdge = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];

endmodule

// File: rtl/stall_accum.sv
module stall_accum
  import stall_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  accCmd_t          cmd,
  input  logic [ACC_W-1:0] chargeStep,
  input  logic [ACC_W-1:0] dischargeStep,
  input  logic [ACC_W-1:0] highThresh,
  input  logic [ACC_W-1:0] lowThresh,
  output accFlags_t        flags
);

  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W:0]   sumWide;

  assign sumWide = {1'b0, acc} + {1'b0, chargeStep};

  always_comb begin
    accNext = acc;
    if (cmd.clear) begin
      accNext = '0;
    end else if (cmd.up) begin
      accNext = sumWide[ACC_W] ? ACC_MAX : sumWide[ACC_W-1:0];
    end else if (cmd.down) begin
      accNext = (dischargeStep > acc) ? '0 : acc - dischargeStep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) acc <= '0;
    else       acc <= accNext;
  end

  assign flags.geHigh = (acc >= highThresh);
  assign flags.ltLow  = (acc <  lowThresh);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (acc == '0)); // R2
  AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.up && !cmd.clear) |=> (acc >= $past(acc))); // R10
  AST_DOWN_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.down && !cmd.clear) |=> (acc <= $past(acc))); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.clear || cmd.up || cmd.down) |=> $stable(acc)); // R3

endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import stall_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fgEdge,
  input  logic      lockDisable,
  input  accFlags_t flags,
  output accCmd_t   cmd,
  output logic      locked
);

  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

  logic [TICK_W-1:0] tickCnt;
  logic              tick;
  lockState_t        state, stateNext;

  // Prescaler: one tick every TICK_DIV cycles
  always_ff @(posedge clk) begin
    if (!rstN)                  tickCnt <= '0;
    else if (tickCnt == TICK_LAST) tickCnt <= '0;
    else                        tickCnt <= tickCnt + 1'b1;
  end

  assign tick = (tickCnt == TICK_LAST);

  // Priority: disable, then rotation edge, then the charge/discharge cycle
  always_comb begin
    cmd       = '0;
    stateNext = state;
    if (lockDisable) begin
      cmd.clear = 1'b1;
      stateNext = ST_RUN;
    end else if (fgEdge) begin
      cmd.clear = 1'b1;
      stateNext = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (flags.geHigh) stateNext = ST_LOCKED;
          else if (tick)    cmd.up    = 1'b1;
        end
        ST_LOCKED: begin
          if (flags.ltLow)  stateNext = ST_RUN;
          else if (tick)    cmd.down  = 1'b1;
        end
        default: stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign locked = (state == ST_LOCKED);

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.clear, cmd.up, cmd.down})); // R3
  AST_LOCK_AT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(flags.geHigh)); // R3
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(flags.ltLow || lockDisable || fgEdge)); // R4
  AST_DISABLE_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    lockDisable |=> !locked); // R8
  AST_EDGE_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    fgEdge |=> !locked); // R7

endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_pkg::*;
#(
  parameter int ACC_W       = 12,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fgIn,
  input  logic             lockDisable,
  input  logic [ACC_W-1:0] chargeStep,
  input  logic [ACC_W-1:0] dischargeStep,
  input  logic [ACC_W-1:0] highThresh,
  input  logic [ACC_W-1:0] lowThresh,
  output logic             lockFlag
);

  logic      fgEdge;
  accCmd_t   cmd;
  accFlags_t flags;

  stall_fg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rstN   (rstN),
    .fgIn   (fgIn),
    .fgEdge (fgEdge)
  );

  stall_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fgEdge      (fgEdge),
    .lockDisable (lockDisable),
    .flags       (flags),
    .cmd         (cmd),
    .locked      (lockFlag)
  );

  stall_accum #(.ACC_W(ACC_W)) u_accum (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .chargeStep    (chargeStep),
    .dischargeStep (dischargeStep),
    .highThresh    (highThresh),
    .lowThresh     (lowThresh),
    .flags         (flags)
  );

endmodule

// File: tb/test_stall_guard.sv
module test_stall_guard;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 12;
  localparam int TICK       = 4;
  localparam int TOL        = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             fgIn;
  logic             lockDisable;
  logic [ACC_W-1:0] chargeStep, dischargeStep, highThresh, lowThresh;
  logic             lockFlag;

  stall_guard #(.ACC_W(ACC_W), .TICK_DIV(TICK)) i_stall_guard (
    .clk(clk), .rstN(rstN), .fgIn(fgIn), .lockDisable(lockDisable),
    .chargeStep(chargeStep), .dischargeStep(dischargeStep),
    .highThresh(highThresh), .lowThresh(lowThresh), .lockFlag(lockFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string req;
    bit    level;
    int    span;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t curItem;
  int  cycleCnt = 0;
  int  markCycle = 0;
  int  spanNow;
  bit  monOn = 1'b0;
  bit  prevFlag = 1'b0;
  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic expectEdge(input string req, input bit level, input int span);
    expItem_t it;
    it.req = req; it.level = level; it.span = span;
    expQ.push_back(it);
  endtask

  task automatic waitDrain(input int cap);
    expItem_t it;
    for (int i = 0; i < cap && expQ.size() > 0; i++) @(negedge clk);
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      check(it.req, 1'b0, -1, it.span);
    end
  endtask

  // Monitor: times each lockFlag change against the expected queue
  always @(negedge clk) begin
    if (monOn && (lockFlag !== prevFlag)) begin
      spanNow = cycleCnt - markCycle;
      if (expQ.size() == 0) begin
        check("unexpected lockFlag change", 1'b0, int'(lockFlag), int'(prevFlag));
      end else begin
        curItem = expQ.pop_front();
        check(curItem.req, (lockFlag == curItem.level) &&
              (spanNow >= curItem.span - TOL) && (spanNow <= curItem.span + TOL),
              spanNow, curItem.span);
      end
      markCycle = cycleCnt;
    end
    prevFlag = lockFlag;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 1'b0, 0, 1);
    summary();
  end

  initial begin
    bit sawLock;
    rstN = 1'b0; fgIn = 1'b0; lockDisable = 1'b0;
    chargeStep = 12'd10; dischargeStep = 12'd1;
    highThresh = 12'd340; lowThresh = 12'd100;
    repeat (5) @(negedge clk);
    check("R1 flag in reset", lockFlag == 1'b0, int'(lockFlag), 0);

    // R3 R4 R5 R6: free-running cycle with the defaults
    rstN = 1'b1;
    markCycle = cycleCnt;
    monOn = 1'b1;
    expectEdge("R3 first lock", 1'b1, 34 * TICK);     // 0 -> 340
    expectEdge("R4 slow release", 1'b0, 241 * TICK);  // 340 -> 99
    expectEdge("R5 short relock", 1'b1, 25 * TICK);   // 99 -> 349
    expectEdge("R6 repeat release", 1'b0, 250 * TICK);// 349 -> 99
    expectEdge("R6 repeat relock", 1'b1, 25 * TICK);
    repeat (2) @(negedge clk);
    check("R1 flag after reset", lockFlag == 1'b0, int'(lockFlag), 0);
    waitDrain(6000);
    monOn = 1'b0;

    // R7: one transition while locked
    check("R7 locked before edge", lockFlag == 1'b1, int'(lockFlag), 1);
    fgIn = ~fgIn;
    repeat (6) @(negedge clk);
    check("R7 edge unlocks", lockFlag == 1'b0, int'(lockFlag), 0);
    repeat (120) @(negedge clk);
    check("R7 recharge from zero", lockFlag == 1'b0, int'(lockFlag), 0);

    // R8: disable while locked, then held
    for (int i = 0; i < 200 && !lockFlag; i++) @(negedge clk);
    lockDisable = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 disable unlocks", lockFlag == 1'b0, int'(lockFlag), 0);
    sawLock = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      sawLock |= lockFlag;
    end
    check("R8 disable holds", !sawLock, int'(sawLock), 0);

    // R2: rotation with edges every 80 cycles (20 ticks, 200 < 340)
    lockDisable = 1'b0;
    sawLock = 1'b0;
    for (int t = 0; t < 25; t++) begin
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        sawLock |= lockFlag;
      end
      fgIn = ~fgIn;
    end
    check("R2 rotating never locks", !sawLock, int'(sawLock), 0);

    // R9: new thresholds and steps at run time
    lockDisable = 1'b1;
    highThresh = 12'd200; lowThresh = 12'd50;
    chargeStep = 12'd20; dischargeStep = 12'd2;
    repeat (4) @(negedge clk);
    lockDisable = 1'b0;
    markCycle = cycleCnt;
    monOn = 1'b1;
    expectEdge("R9 programmed lock", 1'b1, 10 * TICK);     // 0 -> 200
    expectEdge("R9 programmed release", 1'b0, 76 * TICK);  // 200 -> 48
    waitDrain(2000);
    monOn = 1'b0;

    // R10: saturation at both ends
    lockDisable = 1'b1;
    highThresh = 12'd4095; lowThresh = 12'd100;
    chargeStep = 12'd1000; dischargeStep = 12'd3000;
    repeat (4) @(negedge clk);
    lockDisable = 1'b0;
    markCycle = cycleCnt;
    monOn = 1'b1;
    expectEdge("R10 top saturation", 1'b1, 5 * TICK);     // 4000 -> 4095
    expectEdge("R10 bottom saturation", 1'b0, 2 * TICK);  // 1095 -> 0
    waitDrain(500);
    monOn = 1'b0;

    summary();
  end

endmodule